// File: doc/BRIEF.md
# Match Timer with Watchdog Channel

A free-running counter that advances by one on every cycle in which the timer tick input is high. It is paired with a bank of match channels. Each channel holds a compare value. When the counter steps onto that value and the channel's interrupt enable is on, the channel's status bit latches. Each status bit drives one interrupt request line, and software clears it by writing a one to that bit.

The last match channel also serves as a watchdog. Software arms it by setting a watchdog enable bit. Once armed, the watchdog cannot be disarmed until reset. After that, a match on the last channel raises a reset request that stays high until the block itself is reset. Software reaches every register through a simple word-wide bus: a write strobe, an address, write data, and a combinational read-data path.

The address map, with the default of four channels, is:
- address 0: the count.
- addresses 1 to 4: match values for channels 0 to 3.
- address 5: interrupt enables, bit i for channel i.
- address 6: status, write one to clear, bit i for channel i.
- address 7: watchdog enable, bit 0.

Top module: `tmr_match_wdt`

## Requirements
- R1: After reset, the count, all match values, enables, status bits, the watchdog enable, every `irq` line and `wdt_reset` are zero.
- R2: The count increases by one at the clock edge of each cycle with `tick` high, holds when `tick` is low, and wraps from 0xFFFFFFFF to 0.
- R3: A bus write to address 0 loads the count. It takes precedence over a tick in the same cycle, and no channel matches in that cycle.
- R4: Match values are written and read back at address 1+i for channel i.
- R5: When a tick moves the count onto the match value of channel i and enable bit i (address 5) is one, status bit i is set at that same edge. With the enable at zero, the bit stays clear.
- R6: A channel matches only on the tick that brings the count onto its value. A count held by a low `tick` never sets the bit again, even after the bit is cleared.
- R7: Status bits are sticky. Writing address 6 clears each bit written as one. A match in the same cycle as a clear leaves the bit set.
- R8: `irq[i]` equals status bit i.
- R9: Writing one to bit 0 of address 7 sets the watchdog enable, which reads back at bit 0. Writing zero does not clear it. Only reset does.
- R10: With the watchdog enabled, a match on the last channel sets `wdt_reset` at the same edge as its status would set. This happens whatever that channel's interrupt enable is, and `wdt_reset` holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one step per high cycle |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 4 | Interrupt request per channel (status bits) |
| wdt_reset | output | 1 | Sticky system reset request |

## Verification
The compare path is exercised in four ways:
- With a steady tick, a channel sweeps across its match value, so an enabled channel can be told apart from a disabled one.
- With the tick held low on a matching count, followed by a clear, a level-sensitive compare would re-fire and an edge-style one would not.
- A match arriving in the same cycle as a clear shows which of the two wins.
- A count write that coincides with a tick, and a run across 0xFFFFFFFF, expose ordering and wrap errors.

The watchdog is armed with channel 3's interrupt enable off, which separates the reset path from the interrupt path.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        SEL_CNT,
        SEL_MAT,
        SEL_IEN,
        SEL_STS,
        SEL_WDT,
        SEL_NONE
    } tmr_sel_e;

    // Address 0 count, 1..nch match values, then enables, status, watchdog enable.
    function automatic tmr_sel_e tmr_decode(input int a, input int nch);
        if (a == 0)            return SEL_CNT;
        else if (a <= nch)     return SEL_MAT;
        else if (a == nch + 1) return SEL_IEN;
        else if (a == nch + 2) return SEL_STS;
        else if (a == nch + 3) return SEL_WDT;
        else                   return SEL_NONE;
    endfunction

endpackage

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank #(
    parameter int CW  = 32,
    parameter int NCH = 4
) (
    input  logic [CW-1:0]           cnt_nxt,
    input  logic                    adv,
    input  logic [NCH-1:0][CW-1:0]  mat,
    output logic [NCH-1:0]          hit
);

    // One comparator per channel; a hit needs a tick-driven step onto the value.
    for (genvar g = 0; g < NCH; g++) begin : g_cmp
        assign hit[g] = adv && (cnt_nxt == mat[g]);
    end

endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
    import tmr_pkg::*;
#(
    parameter int CW  = 32,
    parameter int NCH = 4,
    parameter int AW  = 3
) (
    input  logic [AW-1:0]           addr,
    input  logic [CW-1:0]           cnt,
    input  logic [NCH-1:0][CW-1:0]  mat,
    input  logic [NCH-1:0]          ien,
    input  logic [NCH-1:0]          sts,
    input  logic                    wen,
    output logic [CW-1:0]           rdata
);

    tmr_sel_e sel;
    assign sel = tmr_decode(int'(addr), NCH);

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CNT: rdata = cnt;
            SEL_MAT: begin
                for (int i = 0; i < NCH; i++) begin
                    if (addr == AW'(i + 1)) rdata = mat[i];
                end
            end
            SEL_IEN: rdata[NCH-1:0] = ien;
            SEL_STS: rdata[NCH-1:0] = sts;
            SEL_WDT: rdata[0] = wen;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_match_wdt.sv
module tmr_match_wdt
    import tmr_pkg::*;
#(
    parameter int CW  = 32,
    parameter int NCH = 4,
    localparam int AW = $clog2(NCH + 4)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic [NCH-1:0] irq,
    output logic          wdt_reset
);

    localparam int WDCH = NCH - 1;

    typedef struct packed {
        logic [CW-1:0]          cnt;
        logic [NCH-1:0][CW-1:0] mat;
        logic [NCH-1:0]         ien;
        logic [NCH-1:0]         sts;
        logic                   wen;
        logic                   wrst;
    } state_t;

    state_t s_q, s_d;

    tmr_sel_e       sel;
    logic           cnt_wr;
    logic           adv;
    logic [CW-1:0]  cnt_inc;
    logic [NCH-1:0] hit;
    logic [NCH-1:0] clr;

    assign sel     = tmr_decode(int'(bus_addr), NCH);
    assign cnt_wr  = bus_we && (sel == SEL_CNT);
    assign adv     = tick && !cnt_wr;
    assign cnt_inc = s_q.cnt + CW'(1);
    assign clr     = (bus_we && (sel == SEL_STS)) ? bus_wdata[NCH-1:0] : '0;

    tmr_cmp_bank #(.CW(CW), .NCH(NCH)) u_cmp (
        .cnt_nxt (cnt_inc),
        .adv     (adv),
        .mat     (s_q.mat),
        .hit     (hit)
    );

    always_comb begin
        s_d = s_q;
        if (cnt_wr)    s_d.cnt = bus_wdata;
        else if (tick) s_d.cnt = cnt_inc;
        for (int i = 0; i < NCH; i++) begin
            if (bus_we && (sel == SEL_MAT) && (bus_addr == AW'(i + 1)))
                s_d.mat[i] = bus_wdata;
        end
        if (bus_we && (sel == SEL_IEN)) s_d.ien = bus_wdata[NCH-1:0];
        s_d.sts  = (s_q.sts & ~clr) | (hit & s_q.ien);
        s_d.wen  = s_q.wen | (bus_we && (sel == SEL_WDT) && bus_wdata[0]);
        s_d.wrst = s_q.wrst | (s_q.wen && hit[WDCH]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq       = s_q.sts;
    assign wdt_reset = s_q.wrst;

    tmr_rd_mux #(.CW(CW), .NCH(NCH), .AW(AW)) u_rd (
        .addr  (bus_addr),
        .cnt   (s_q.cnt),
        .mat   (s_q.mat),
        .ien   (s_q.ien),
        .sts   (s_q.sts),
        .wen   (s_q.wen),
        .rdata (bus_rdata)
    );

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick) && !$past(cnt_wr)) |-> (s_q.cnt == $past(s_q.cnt) + CW'(1)));

    // R5
    sts_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sts & ~$past(s_q.sts) & ~$past(s_q.ien)) == '0);

    // R6
    sts_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(s_q.sts & ~$past(s_q.sts))) |-> $past(tick));

    // R9
    wdt_en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(s_q.wen) |-> s_q.wen);

    // R10
    wdt_rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wdt_reset) |-> wdt_reset);

endmodule

// File: tb/tmr_match_wdt_test.sv
module tmr_match_wdt_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    logic        wdt_reset;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [31:0] m_cnt;
    logic [31:0] m_mat [4];
    logic [3:0]  m_ien, m_st;
    logic        m_wen, m_wrst;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmr_match_wdt uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .wdt_reset (wdt_reset)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read(input int a);
        case (a)
            0:       return m_cnt;
            1, 2, 3, 4: return m_mat[a-1];
            5:       return {28'd0, m_ien};
            6:       return {28'd0, m_st};
            7:       return {31'd0, m_wen};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_step();
        logic [3:0]  h;
        logic [31:0] nx;
        bit          cw;
        if (!rst_n) begin
            m_cnt = 0; m_ien = 0; m_st = 0; m_wen = 0; m_wrst = 0;
            for (int i = 0; i < 4; i++) m_mat[i] = 0;
            return;
        end
        cw = bus_we && bus_addr == 0;
        nx = m_cnt + 1;
        for (int i = 0; i < 4; i++) h[i] = tick && !cw && (nx == m_mat[i]);
        m_wrst = m_wrst | (m_wen && h[3]);
        m_st   = (m_st & ~((bus_we && bus_addr == 6) ? bus_wdata[3:0] : 4'd0)) | (h & m_ien);
        m_wen  = m_wen | (bus_we && bus_addr == 7 && bus_wdata[0]);
        if (bus_we && bus_addr == 5) m_ien = bus_wdata[3:0];
        for (int i = 0; i < 4; i++) if (bus_we && bus_addr == 3'(i + 1)) m_mat[i] = bus_wdata;
        if (cw) m_cnt = bus_wdata;
        else if (tick) m_cnt = nx;
    endtask

    task automatic compare();
        string rt;
        case (bus_addr)
            0:          rt = "R2 count read";
            1, 2, 3, 4: rt = "R4 match read";
            5:          rt = "R5 enable read";
            6:          rt = "R7 status read";
            default:    rt = "R9 wdt enable read";
        endcase
        chk("R8 irq", {28'd0, irq}, {28'd0, m_st});
        chk("R10 wdt_reset", {31'd0, wdt_reset}, {31'd0, m_wrst});
        chk(rt, bus_rdata, m_read(int'(bus_addr)));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic drive(input bit t, input bit we, input int a, input logic [31:0] d);
        tick = t; bus_we = we; bus_addr = 3'(a); bus_wdata = d;
        cyc();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog timeout: actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) cyc();
        // R1 reset state
        chk("R1 outputs", {27'd0, wdt_reset, irq}, 32'd0);
        chk("R1 count", bus_rdata, 32'd0);
        rst_n = 1'b1;

        // R2 irregular tick pattern
        for (int i = 0; i < 20; i++) drive(i % 3 != 0, 0, 0, 0);
        chk("R2 count after pattern", bus_rdata, 32'd13);

        // R5 enabled channel 0 sweeps past its value
        drive(0, 1, 1, 32'd20);
        drive(0, 1, 5, 32'd1);
        drive(0, 1, 0, 32'd15);
        for (int i = 0; i < 8; i++) drive(1, 0, 6, 0);
        chk("R5 ch0 set", {31'd0, irq[0]}, 32'd1);

        // R5 disabled channel 1 passes without setting
        drive(0, 1, 2, 32'd26);
        for (int i = 0; i < 5; i++) drive(1, 0, 6, 0);
        chk("R5 ch1 stays clear", {31'd0, irq[1]}, 32'd0);

        // R6 hold on a matching count, then clear
        drive(0, 1, 3, 32'd40);
        drive(0, 1, 5, 32'd5);
        drive(0, 1, 0, 32'd39);
        drive(1, 0, 6, 0);
        chk("R6 ch2 set on step", {31'd0, irq[2]}, 32'd1);
        for (int i = 0; i < 3; i++) drive(0, 0, 6, 0);
        drive(0, 1, 6, 32'd4);
        for (int i = 0; i < 4; i++) drive(0, 0, 6, 0);
        chk("R6 no retrigger", {31'd0, irq[2]}, 32'd0);

        // R7 match and clear in the same cycle
        drive(0, 1, 0, 32'd38);
        drive(1, 0, 6, 0);
        drive(1, 1, 6, 32'd4);
        chk("R7 set wins", {31'd0, irq[2]}, 32'd1);
        for (int i = 0; i < 3; i++) drive(1, 0, 6, 0);
        chk("R7 sticky", {31'd0, irq[2]}, 32'd1);

        // R3 write beats tick, then R2 wrap
        drive(1, 1, 0, 32'hFFFF_FFFE);
        chk("R3 write wins", bus_rdata, 32'hFFFF_FFFE);
        drive(1, 0, 0, 0);
        drive(1, 0, 0, 0);
        chk("R2 wrap", bus_rdata, 32'd0);

        // R4 read back every match value
        for (int a = 1; a <= 4; a++) drive(0, 0, a, 0);

        // R9 arm watchdog, try to disarm
        drive(0, 1, 7, 32'd1);
        drive(0, 1, 7, 32'd0);
        chk("R9 enable sticky", bus_rdata, 32'd1);

        // R10 channel 3 match with its interrupt enable off
        drive(0, 1, 4, 32'd3);
        for (int i = 0; i < 3; i++) drive(1, 0, 6, 0);
        chk("R10 reset request", {31'd0, wdt_reset}, 32'd1);
        chk("R10 irq3 off", {31'd0, irq[3]}, 32'd0);
        for (int i = 0; i < 3; i++) drive(1, 0, 6, 0);
        chk("R10 holds", {31'd0, wdt_reset}, 32'd1);

        // R1 reset clears watchdog state
        rst_n = 1'b0;
        drive(0, 0, 7, 0);
        drive(0, 0, 7, 0);
        rst_n = 1'b1;
        drive(0, 0, 7, 0);
        chk("R1 wdt cleared", {31'd0, wdt_reset}, 32'd0);
        chk("R1 wdt enable cleared", bus_rdata, 32'd0);

        summary();
    end

endmodule